// File: doc/BRIEF.md
# PIO Completion Status Resolver

This block turns the outcome of one programmed-I/O configuration access into a verdict for software. A start pulse latches the access description: read or write, byte offset, size in bytes, and whether the root port's retry-visibility enable is on. The block then waits for the completion of the access. When the completion arrives it decodes the completion code and the separate error flag, and produces a pass or fail flag, an error category, and the returned read data. The read data is shifted and masked to the requested byte lane and width.

The wait is bounded. A microsecond strobe advances a poll counter, and the access is declared timed out after `POLL_LIMIT` strobes. A configuration-retry answer is a special case. It is either converted into a synthetic vendor-ID word that software treats as "retry later", or it is reported as an error. The same applies when the access engine is already busy at start and when the poll times out. Results are registered, marked by a one-cycle `done` pulse, and held until the next accepted start.

Top module: `pio_cpl_resolver`

## Requirements
- R1: Completion code 0 with the error flag clear passes. A read then returns the completion data, and a write returns data 0.
- R2: Completion code 0 with the error flag set fails with category 1 (completion error).
- R3: Code 1 (unsupported request) fails a write with category 2. For a read it passes and returns 0xFFFFFFFF before lane alignment.
- R4: Code 2 (configuration retry) passes with data 0xFFFF0001 when retry reporting is allowed. Otherwise it fails with category 3.
- R5: Retry reporting is allowed only for a read at byte offset 0 with size 4 while `crsVisEn` is high. A write never qualifies.
- R6: Code 4 (completer abort) fails both reads and writes with category 4. Codes 3, 5, 6 and 7 fail with category 5 (unknown).
- R7: A start while `engineBusy` is high produces a result in the next cycle without polling. The result is a pass with 0xFFFF0001 if retry reporting is allowed, and otherwise a failure with category 7.
- R8: With no completion, the access ends on exactly the `POLL_LIMIT`-th `usTick` strobe after the start. The result is a pass with 0xFFFF0001 if retry reporting is allowed, and otherwise a failure with category 6.
- R9: For a passing read, `accSize` is a byte count. A value of 1 returns `(data >> 8*offset[1:0]) & 0xFF`. A value of 2 returns the same shift masked with 0xFFFF. Any other value returns the full word.
- R10: A failing read returns 0xFFFFFFFF, and any write returns 0. A pass always reports category 0.
- R11: `done` is high for one cycle per result. `pass`, `errCat` and `rdData` hold until the next accepted start, which clears them to 0.
- R12: A start pulse while a completion is being awaited is ignored.
- R13: After reset `done`, `pass`, `errCat` and `rdData` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Begins one access when idle |
| isRead | input | 1 | 1 = read access, 0 = write access |
| byteOffset | input | OFF_W | Configuration byte offset of the access |
| accSize | input | 3 | Access size in bytes (1, 2 or 4) |
| crsVisEn | input | 1 | Root-control retry software-visibility enable |
| engineBusy | input | 1 | Access engine already running at start |
| usTick | input | 1 | One-microsecond poll strobe |
| cplValid | input | 1 | Completion has arrived this cycle |
| cplCode | input | 3 | Completion status code |
| cplErrFlag | input | 1 | Separate completion error flag |
| cplData | input | 32 | Raw completion read data |
| done | output | 1 | One-cycle result strobe |
| pass | output | 1 | Access verdict, 1 = success |
| errCat | output | 3 | Error category, 0 when passing |
| rdData | output | 32 | Aligned read data |

## Verification
The bench builds the block with `POLL_LIMIT` set to 6 instead of the 1.5 s default. This makes the timeout boundary reachable in a few dozen cycles. The bench checks that no result appears after five strobes and that one appears on the sixth. Every completion code is applied in both read and write direction. The bench also covers each qualifier that can deny retry reporting, and each byte lane and width of the alignment path.

// File: rtl/pio_res_pkg.sv
package pio_res_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [2:0] {
    CAT_NONE    = 3'd0,
    CAT_CPL_ERR = 3'd1,
    CAT_UNSUP   = 3'd2,
    CAT_RETRY   = 3'd3,
    CAT_ABORT   = 3'd4,
    CAT_UNKNOWN = 3'd5,
    CAT_TIMEOUT = 3'd6,
    CAT_BUSY    = 3'd7
  } err_cat_e;

  localparam logic [2:0] CODE_OK    = 3'd0;
  localparam logic [2:0] CODE_UNSUP = 3'd1;
  localparam logic [2:0] CODE_RETRY = 3'd2;
  localparam logic [2:0] CODE_ABORT = 3'd4;

  localparam logic [WORD_W-1:0] RETRY_WORD = 32'hFFFF_0001;
  localparam logic [WORD_W-1:0] ALL_ONES   = '1;

  // control-to-datapath strobes
  typedef struct packed {
    logic capture;     // accepted start: latch access description
    logic evalCpl;     // completion arrived: decode it
    logic evalBusy;    // engine busy at start
    logic evalTimeout; // poll budget exhausted
  } strobe_t;

endpackage

// File: rtl/pio_res_ctrl.sv
module pio_res_ctrl
  import pio_res_pkg::*;
#(
  parameter int POLL_LIMIT = 1500000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startPulse,
  input  logic    engineBusy,
  input  logic    usTick,
  input  logic    cplValid,
  output strobe_t strobes,
  output logic    done
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(POLL_LIMIT - 1);

  typedef enum logic {ST_IDLE, ST_POLL} state_e;

  state_e           state, nextState;
  logic [CNT_W-1:0] tickCnt;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strobes.capture = 1'b1;
          if (engineBusy) strobes.evalBusy = 1'b1;
          else            nextState = ST_POLL;
        end
      end
      ST_POLL: begin
        if (cplValid) begin
          strobes.evalCpl = 1'b1;
          nextState       = ST_IDLE;
        end else if (usTick && (tickCnt == LAST_TICK)) begin
          strobes.evalTimeout = 1'b1;
          nextState           = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      tickCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strobes.evalCpl | strobes.evalBusy | strobes.evalTimeout;
      if (strobes.capture)
        tickCnt <= '0;
      else if ((state == ST_POLL) && usTick && !cplValid)
        tickCnt <= tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/pio_res_dpath.sv
module pio_res_dpath
  import pio_res_pkg::*;
#(
  parameter int OFF_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              isRead,
  input  logic [OFF_W-1:0]  byteOffset,
  input  logic [2:0]        accSize,
  input  logic              crsVisEn,
  input  logic [2:0]        cplCode,
  input  logic              cplErrFlag,
  input  logic [WORD_W-1:0] cplData,
  output logic              pass,
  output logic [2:0]        errCat,
  output logic [WORD_W-1:0] rdData
);

  // latched access description
  logic       qRead, qOffZero, qVis;
  logic [1:0] qLane;
  logic [2:0] qSize;

  // effective description: live on the start cycle, latched afterwards
  logic       effRead, effOffZero, effVis;
  logic [1:0] effLane;
  logic [2:0] effSize;
  logic       retryOk;

  logic              okNow;
  err_cat_e          catNow;
  logic [WORD_W-1:0] rawNow, dataNow, shifted;
  logic              evalAny;

  assign effRead    = strobes.capture ? isRead               : qRead;
  assign effOffZero = strobes.capture ? (byteOffset == '0)   : qOffZero;
  assign effVis     = strobes.capture ? crsVisEn             : qVis;
  assign effLane    = strobes.capture ? byteOffset[1:0]      : qLane;
  assign effSize    = strobes.capture ? accSize              : qSize;

  assign retryOk = effRead && effOffZero && (effSize == 3'd4) && effVis;
  assign evalAny = strobes.evalCpl | strobes.evalBusy | strobes.evalTimeout;

  always_comb begin
    okNow  = 1'b0;
    catNow = CAT_NONE;
    rawNow = ALL_ONES;
    if (strobes.evalCpl) begin
      unique case (cplCode)
        CODE_OK: begin
          if (cplErrFlag) catNow = CAT_CPL_ERR;
          else begin
            okNow  = 1'b1;
            rawNow = cplData;
          end
        end
        CODE_UNSUP: begin
          if (effRead) okNow  = 1'b1;
          else         catNow = CAT_UNSUP;
        end
        CODE_RETRY: begin
          if (retryOk) begin
            okNow  = 1'b1;
            rawNow = RETRY_WORD;
          end else catNow = CAT_RETRY;
        end
        CODE_ABORT: catNow = CAT_ABORT;
        default:    catNow = CAT_UNKNOWN;
      endcase
    end else if (retryOk) begin
      okNow  = 1'b1;
      rawNow = RETRY_WORD;
    end else begin
      catNow = strobes.evalBusy ? CAT_BUSY : CAT_TIMEOUT;
    end
  end

  assign shifted = rawNow >> {effLane, 3'b000};

  always_comb begin
    if (!effRead)   dataNow = '0;
    else if (!okNow) dataNow = ALL_ONES;
    else begin
      unique case (effSize)
        3'd1:    dataNow = {{(WORD_W-8){1'b0}},  shifted[7:0]};
        3'd2:    dataNow = {{(WORD_W-16){1'b0}}, shifted[15:0]};
        default: dataNow = rawNow;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qRead    <= 1'b0;
      qOffZero <= 1'b0;
      qVis     <= 1'b0;
      qLane    <= '0;
      qSize    <= '0;
      pass     <= 1'b0;
      errCat   <= CAT_NONE;
      rdData   <= '0;
    end else begin
      if (strobes.capture) begin
        qRead    <= isRead;
        qOffZero <= (byteOffset == '0);
        qVis     <= crsVisEn;
        qLane    <= byteOffset[1:0];
        qSize    <= accSize;
      end
      if (evalAny) begin
        pass   <= okNow;
        errCat <= catNow;
        rdData <= dataNow;
      end else if (strobes.capture) begin
        pass   <= 1'b0;
        errCat <= CAT_NONE;
        rdData <= '0;
      end
    end
  end

endmodule

// File: rtl/pio_cpl_resolver.sv
module pio_cpl_resolver
  import pio_res_pkg::*;
#(
  parameter int POLL_LIMIT = 1500000,
  parameter int OFF_W      = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              isRead,
  input  logic [OFF_W-1:0]  byteOffset,
  input  logic [2:0]        accSize,
  input  logic              crsVisEn,
  input  logic              engineBusy,
  input  logic              usTick,
  input  logic              cplValid,
  input  logic [2:0]        cplCode,
  input  logic              cplErrFlag,
  input  logic [31:0]       cplData,
  output logic              done,
  output logic              pass,
  output logic [2:0]        errCat,
  output logic [31:0]       rdData
);

  strobe_t strobes;

  pio_res_ctrl #(.POLL_LIMIT(POLL_LIMIT)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .engineBusy (engineBusy),
    .usTick     (usTick),
    .cplValid   (cplValid),
    .strobes    (strobes),
    .done       (done)
  );

  pio_res_dpath #(.OFF_W(OFF_W)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .isRead     (isRead),
    .byteOffset (byteOffset),
    .accSize    (accSize),
    .crsVisEn   (crsVisEn),
    .cplCode    (cplCode),
    .cplErrFlag (cplErrFlag),
    .cplData    (cplData),
    .pass       (pass),
    .errCat     (errCat),
    .rdData     (rdData)
  );

endmodule

// File: rtl/pio_cpl_resolver_chk.sv
module pio_cpl_resolver_chk #(
  parameter int POLL_LIMIT = 1500000
) (
  input logic        clk,
  input logic        rstN,
  input logic        startPulse,
  input logic        isRead,
  input logic        engineBusy,
  input logic        usTick,
  input logic        done,
  input logic        pass,
  input logic [2:0]  errCat,
  input logic [31:0] rdData
);

  localparam int CNT_W = $clog2(POLL_LIMIT + 2);

  logic             pending, lastRead, accepted;
  logic [CNT_W-1:0] tickCnt;

  assign accepted = startPulse && (!pending || done);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      lastRead <= 1'b0;
      tickCnt  <= '0;
    end else if (accepted) begin
      pending  <= 1'b1;
      lastRead <= isRead;
      tickCnt  <= '0;
    end else begin
      if (done) pending <= 1'b0;
      if (pending && !done && usTick) tickCnt <= tickCnt + 1'b1;
    end
  end

  p_pass_cat_none_r10: assert property (@(posedge clk) disable iff (!rstN)
    pass |-> (errCat == 3'd0));

  p_fail_cat_set_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass) |-> (errCat != 3'd0));

  p_fail_read_ones_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !pass && lastRead) |-> (rdData == 32'hFFFF_FFFF));

  p_write_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !lastRead) |-> (rdData == 32'd0));

  p_busy_immediate_r7: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && engineBusy) |=> (done && (pass || errCat == 3'd7)));

  p_done_only_pending_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> pending);

  p_clear_on_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && !engineBusy) |=> (!done && !pass && errCat == 3'd0 && rdData == 32'd0));

  p_poll_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !done) |-> (tickCnt < CNT_W'(POLL_LIMIT)));

endmodule

bind pio_cpl_resolver pio_cpl_resolver_chk #(.POLL_LIMIT(POLL_LIMIT)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .startPulse (startPulse),
  .isRead     (isRead),
  .engineBusy (engineBusy),
  .usTick     (usTick),
  .done       (done),
  .pass       (pass),
  .errCat     (errCat),
  .rdData     (rdData)
);

// File: tb/pio_cpl_resolver_tb_top.sv
module pio_cpl_resolver_tb_top;

  localparam int LIMIT = 6;
  localparam int OFFW  = 12;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic        isRead = 1'b0;
  logic [OFFW-1:0] byteOffset = '0;
  logic [2:0]  accSize = 3'd4;
  logic        crsVisEn = 1'b0;
  logic        engineBusy = 1'b0;
  logic        usTick = 1'b0;
  logic        cplValid = 1'b0;
  logic [2:0]  cplCode = 3'd0;
  logic        cplErrFlag = 1'b0;
  logic [31:0] cplData = '0;
  logic        done, pass;
  logic [2:0]  errCat;
  logic [31:0] rdData;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pio_cpl_resolver #(.POLL_LIMIT(LIMIT), .OFF_W(OFFW)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .isRead(isRead),
    .byteOffset(byteOffset), .accSize(accSize), .crsVisEn(crsVisEn),
    .engineBusy(engineBusy), .usTick(usTick), .cplValid(cplValid),
    .cplCode(cplCode), .cplErrFlag(cplErrFlag), .cplData(cplData),
    .done(done), .pass(pass), .errCat(errCat), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic expectResult(input string tag, input bit expPass,
                              input logic [2:0] expCat, input logic [31:0] expData);
    chk({tag, " done"}, 32'(done), 32'd1);
    chk({tag, " pass"}, 32'(pass), 32'(expPass));
    chk({tag, " cat"},  32'(errCat), 32'(expCat));
    chk({tag, " data"}, rdData, expData);
  endtask

  task automatic startAccess(input bit rd, input logic [OFFW-1:0] off,
                             input logic [2:0] sz, input bit vis, input bit busy);
    isRead = rd; byteOffset = off; accSize = sz; crsVisEn = vis;
    engineBusy = busy; startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0; engineBusy = 1'b0;
  endtask

  task automatic complete(input logic [2:0] code, input bit err, input logic [31:0] data);
    cplCode = code; cplErrFlag = err; cplData = data; cplValid = 1'b1;
    @(negedge clk);
    cplValid = 1'b0;
  endtask

  task automatic tick();
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
    @(negedge clk);
  endtask

  task automatic access(input string tag, input bit rd, input logic [OFFW-1:0] off,
                        input logic [2:0] sz, input bit vis, input logic [2:0] code,
                        input bit err, input logic [31:0] data, input bit expPass,
                        input logic [2:0] expCat, input logic [31:0] expData);
    startAccess(rd, off, sz, vis, 1'b0);
    @(negedge clk);
    complete(code, err, data);
    expectResult(tag, expPass, expCat, expData);
    @(negedge clk);
  endtask

  task automatic t_reset_r13();
    chk("R13 done", 32'(done), 0);
    chk("R13 pass", 32'(pass), 0);
    chk("R13 cat",  32'(errCat), 0);
    chk("R13 data", rdData, 0);
  endtask

  task automatic t_success_r1();
    access("R1 read ok", 1, 0, 4, 0, 3'd0, 0, 32'h1234_5678, 1, 0, 32'h1234_5678);
    access("R1 write ok", 0, 12'h010, 4, 0, 3'd0, 0, 32'hDEAD_BEEF, 1, 0, 32'h0);
  endtask

  task automatic t_cpl_err_r2();
    access("R2 read err flag", 1, 0, 4, 1, 3'd0, 1, 32'h1111_2222, 0, 1, 32'hFFFF_FFFF);
    access("R2 write err flag", 0, 0, 4, 0, 3'd0, 1, 32'h0, 0, 1, 32'h0);
  endtask

  task automatic t_unsup_r3();
    access("R3 read unsup", 1, 12'h004, 4, 0, 3'd1, 0, 32'h0, 1, 0, 32'hFFFF_FFFF);
    access("R3 read unsup byte", 1, 12'h006, 1, 0, 3'd1, 0, 32'h0, 1, 0, 32'h0000_00FF);
    access("R3 write unsup", 0, 12'h004, 4, 0, 3'd1, 0, 32'h0, 0, 2, 32'h0);
  endtask

  task automatic t_retry_r4_r5();
    access("R4 retry allowed", 1, 0, 4, 1, 3'd2, 0, 32'h0, 1, 0, 32'hFFFF_0001);
    access("R4 retry vis off", 1, 0, 4, 0, 3'd2, 0, 32'h0, 0, 3, 32'hFFFF_FFFF);
    access("R5 retry offset 4", 1, 12'h004, 4, 1, 3'd2, 0, 32'h0, 0, 3, 32'hFFFF_FFFF);
    access("R5 retry size 2", 1, 0, 2, 1, 3'd2, 0, 32'h0, 0, 3, 32'hFFFF_FFFF);
    access("R5 retry write", 0, 0, 4, 1, 3'd2, 0, 32'h0, 0, 3, 32'h0);
  endtask

  task automatic t_abort_unknown_r6();
    access("R6 read abort", 1, 0, 4, 1, 3'd4, 0, 32'h0, 0, 4, 32'hFFFF_FFFF);
    access("R6 write abort", 0, 0, 4, 0, 3'd4, 0, 32'h0, 0, 4, 32'h0);
    for (int c = 3; c < 8; c++) begin
      if (c != 4)
        access($sformatf("R6 unknown code %0d", c), 1, 0, 4, 0, 3'(c), 0,
               32'h0, 0, 5, 32'hFFFF_FFFF);
    end
  endtask

  task automatic t_busy_r7();
    startAccess(1, 0, 4, 1, 1);
    expectResult("R7 busy retry ok", 1, 0, 32'hFFFF_0001);
    @(negedge clk);
    startAccess(1, 12'h008, 4, 1, 1);
    expectResult("R7 busy read fail", 0, 7, 32'hFFFF_FFFF);
    @(negedge clk);
    startAccess(0, 0, 4, 1, 1);
    expectResult("R7 busy write fail", 0, 7, 32'h0);
    @(negedge clk);
  endtask

  task automatic t_timeout_r8();
    startAccess(1, 12'h020, 4, 0, 0);
    for (int i = 0; i < LIMIT - 1; i++) tick();
    chk("R8 no result before limit", 32'(done), 0);
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
    expectResult("R8 timeout fail", 0, 6, 32'hFFFF_FFFF);
    @(negedge clk);
    startAccess(1, 0, 4, 1, 0);
    for (int i = 0; i < LIMIT - 1; i++) tick();
    chk("R8 no result before limit allowed", 32'(done), 0);
    usTick = 1'b1;
    @(negedge clk);
    usTick = 1'b0;
    expectResult("R8 timeout retry ok", 1, 0, 32'hFFFF_0001);
    @(negedge clk);
  endtask

  task automatic t_align_r9();
    access("R9 byte lane 1", 1, 12'h105, 1, 0, 3'd0, 0, 32'hA1B2_C3D4, 1, 0, 32'h0000_00C3);
    access("R9 byte lane 3", 1, 12'h00B, 1, 0, 3'd0, 0, 32'hA1B2_C3D4, 1, 0, 32'h0000_00A1);
    access("R9 byte lane 0", 1, 12'h040, 1, 0, 3'd0, 0, 32'hA1B2_C3D4, 1, 0, 32'h0000_00D4);
    access("R9 half upper", 1, 12'h002, 2, 0, 3'd0, 0, 32'hA1B2_C3D4, 1, 0, 32'h0000_A1B2);
    access("R9 half lower", 1, 12'h00C, 2, 0, 3'd0, 0, 32'hA1B2_C3D4, 1, 0, 32'h0000_C3D4);
  endtask

  task automatic t_hold_r11();
    startAccess(1, 0, 4, 0, 0);
    @(negedge clk);
    complete(3'd4, 0, 32'h0);
    expectResult("R11 result", 0, 4, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk);
    chk("R11 done pulse single", 32'(done), 0);
    chk("R11 cat held", 32'(errCat), 4);
    chk("R11 data held", rdData, 32'hFFFF_FFFF);
    startAccess(1, 0, 4, 0, 0);
    chk("R11 cleared pass", 32'(pass), 0);
    chk("R11 cleared cat", 32'(errCat), 0);
    chk("R11 cleared data", rdData, 0);
    complete(3'd0, 0, 32'h0BAD_F00D);
    expectResult("R11 next result", 1, 0, 32'h0BAD_F00D);
    @(negedge clk);
  endtask

  task automatic t_ignore_start_r12();
    startAccess(1, 0, 4, 0, 0);
    startAccess(0, 12'h001, 1, 1, 1);
    chk("R12 no result from ignored start", 32'(done), 0);
    complete(3'd0, 0, 32'h0000_55AA);
    expectResult("R12 original access kept", 1, 0, 32'h0000_55AA);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r13();
    t_success_r1();
    t_cpl_err_r2();
    t_unsup_r3();
    t_retry_r4_r5();
    t_abort_unknown_r6();
    t_busy_r7();
    t_timeout_r8();
    t_align_r9();
    t_hold_r11();
    t_ignore_start_r12();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule